// File: doc/BRIEF.md
# PWM Fault Guard

This block sits between a PWM waveform generator and the output pads. It watches a small set of external fault inputs and drives a channel's high-side and low-side outputs to safe levels when a fault that the channel listens to becomes active. Each fault has its own active-level setting and its own status behaviour. In follow mode the status tracks the filtered fault level. In hold mode the status stays set until software releases it. Each channel has its own enable bits, one per fault, and its own safe high and low levels.

The forcing path works directly on the pin level after polarity adjustment. An active fault therefore overrides the waveform in the same cycle, with no wait for a counter step or a period boundary. While a channel is forced, the block also holds that channel's period counter in reset, so the counter starts again from zero when protection is released. The status path is slower. It runs each fault through a two-stage synchronizer and a stability filter, and it sets a pending interrupt bit when a fault's status rises. A pulse on the status-read strobe clears every pending bit, whether or not the fault is still present.

Top module: `pwm_fault_guard`

## Requirements
- R1: When no enabled fault of a channel is active at its pin or held in status, `pwm_h_out`/`pwm_l_out` equal `pwm_h_in`/`pwm_l_in` and `cnt_rst` is 0 for that channel.
- R2: Bit `x*NF+y` of `cfg_en` makes fault y protect channel x. While such a fault is active at its pin, channel x drives `cfg_hval[x]` on `pwm_h_out[x]` and `cfg_lval[x]` on `pwm_l_out[x]` in the same cycle, without waiting for a clock edge.
- R3: `cfg_pol[y]`=1 makes a high level on `flt_raw[y]` the active level, and `cfg_pol[y]`=0 makes a low level the active level. This applies to both forcing and status.
- R4: `cnt_rst[x]` is high in every cycle in which channel x is forced.
- R5: A fault level held for fewer than FILT_LEN clock cycles never sets status. A level held long enough sets `flt_status[y]` at the (FILT_LEN+3)-th rising edge that samples it, which is the 6th edge for the default FILT_LEN=3.
- R6: With `cfg_mode[y]`=0 (follow), status falls with the same latency after the fault goes inactive. A forced channel then returns to its waveform in the cycle in which its last enabling status falls.
- R7: With `cfg_mode[y]`=1 (hold), status stays set after the fault goes away. A `flt_clr[y]` pulse clears it at the next edge only if the filtered fault is inactive. A clear pulse given while the fault is active is ignored.
- R8: While a held status is set, every channel it is enabled for stays forced with `cnt_rst` high. Both are released in the cycle after the accepted clear.
- R9: `irq_pend[y]` is set at the edge where `flt_status[y]` rises, but only if `irq_en[y]`=1 and `irq_mask[y]`=0. `irq` is the OR of all pending bits.
- R10: A one-cycle `sts_rd` pulse clears all pending bits at the next edge, even while the fault stays active. A fault whose level stays active does not raise a new pending bit.
- R11: If a status rise and `sts_rd` fall on the same edge, the new pending bit for that fault survives and all other pending bits are cleared.
- R12: Switching a fault to hold mode while its input is inactive does not set its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_raw | input | NF | Fault pins, asynchronous |
| cfg_pol | input | NF | Active level per fault (1 = high) |
| cfg_mode | input | NF | Status mode per fault (0 follow, 1 hold) |
| cfg_en | input | NCH*NF | Enable bit x*NF+y: fault y protects channel x |
| cfg_hval | input | NCH | Safe high-side level per channel |
| cfg_lval | input | NCH | Safe low-side level per channel |
| irq_en | input | NF | Interrupt enable per fault |
| irq_mask | input | NF | Interrupt mask per fault (1 = blocked) |
| flt_clr | input | NF | Release pulse for held status |
| sts_rd | input | 1 | Status-read strobe, clears pending bits |
| pwm_h_in | input | NCH | High-side waveform from generator |
| pwm_l_in | input | NCH | Low-side waveform from generator |
| pwm_h_out | output | NCH | Guarded high-side output |
| pwm_l_out | output | NCH | Guarded low-side output |
| cnt_rst | output | NCH | Counter reset request per channel |
| flt_status | output | NF | Fault status per fault |
| irq_pend | output | NF | Pending fault interrupt per fault |
| irq | output | 1 | Fault interrupt, separate from period interrupts |

## Verification
A status-read strobe and a new fault status rise can land on the same clock edge. Whether the fresh pending bit survives then depends on the priority inside the status logic. The bench makes this collision happen on purpose. It holds one fault's pending bit, raises a second fault, and times the read pulse so that the read is sampled at exactly the edge where the second status rises. It passes only if the first pending bit is cleared and the second one remains set. It then issues another read and checks that this read clears the second bit.

// File: rtl/pfg_pkg.sv
`timescale 1ns/1ps
package pfg_pkg;

    typedef enum logic {
        MODE_FOLLOW = 1'b0,
        MODE_HOLD   = 1'b1
    } flt_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } drv_pair_t;

    // Polarity-adjusted fault level: 1 means the fault is asserted.
    function automatic logic fault_active(input logic lvl, input logic pol);
        return lvl ~^ pol;
    endfunction

endpackage

// File: rtl/pfg_filter.sv
`timescale 1ns/1ps
module pfg_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic act_raw,
    output logic act_filt
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            run_q  <= '0;
            filt_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], act_raw};
            if (sync_q[1] == filt_q) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                filt_q <= sync_q[1];
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign act_filt = filt_q;
endmodule

// File: rtl/pfg_status.sv
`timescale 1ns/1ps
module pfg_status
    import pfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      filt,
    input  flt_mode_e mode,
    input  logic      clr,
    input  logic      irq_on,
    input  logic      rd,
    output logic      st,
    output logic      pend
);
    logic st_q, st_nxt, pend_q;

    always_comb begin
        unique case (mode)
            MODE_FOLLOW: st_nxt = filt;
            MODE_HOLD:   st_nxt = filt | (st_q & ~clr);
            default:     st_nxt = filt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            st_q <= st_nxt;
            if (st_nxt && !st_q && irq_on)
                pend_q <= 1'b1;
            else if (rd)
                pend_q <= 1'b0;
        end
    end

    assign st   = st_q;
    assign pend = pend_q;
endmodule

// File: rtl/pfg_force.sv
`timescale 1ns/1ps
module pfg_force
    import pfg_pkg::*;
#(
    parameter int NCH = 4,
    parameter int NF  = 3
) (
    input  logic [NF-1:0]     act_raw,
    input  logic [NF-1:0]     status,
    input  logic [NCH*NF-1:0] en,
    input  logic [NCH-1:0]    hval,
    input  logic [NCH-1:0]    lval,
    input  logic [NCH-1:0]    h_in,
    input  logic [NCH-1:0]    l_in,
    output logic [NCH-1:0]    h_out,
    output logic [NCH-1:0]    l_out,
    output logic [NCH-1:0]    trip
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [NF-1:0] hit;
        drv_pair_t     wave, safe, drv;

        assign hit  = en[ch*NF +: NF] & (act_raw | status);
        assign wave = '{hi: h_in[ch], lo: l_in[ch]};
        assign safe = '{hi: hval[ch], lo: lval[ch]};
        assign drv  = (|hit) ? safe : wave;

        assign h_out[ch] = drv.hi;
        assign l_out[ch] = drv.lo;
        assign trip[ch]  = |hit;
    end
endmodule

// File: rtl/pwm_fault_guard.sv
`timescale 1ns/1ps
module pwm_fault_guard
    import pfg_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int NF       = 3,
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NF-1:0]     flt_raw,
    input  logic [NF-1:0]     cfg_pol,
    input  logic [NF-1:0]     cfg_mode,
    input  logic [NCH*NF-1:0] cfg_en,
    input  logic [NCH-1:0]    cfg_hval,
    input  logic [NCH-1:0]    cfg_lval,
    input  logic [NF-1:0]     irq_en,
    input  logic [NF-1:0]     irq_mask,
    input  logic [NF-1:0]     flt_clr,
    input  logic              sts_rd,
    input  logic [NCH-1:0]    pwm_h_in,
    input  logic [NCH-1:0]    pwm_l_in,
    output logic [NCH-1:0]    pwm_h_out,
    output logic [NCH-1:0]    pwm_l_out,
    output logic [NCH-1:0]    cnt_rst,
    output logic [NF-1:0]     flt_status,
    output logic [NF-1:0]     irq_pend,
    output logic              irq
);
    logic [NF-1:0] act_raw;
    logic [NF-1:0] act_filt;

    for (genvar f = 0; f < NF; f++) begin : g_flt
        assign act_raw[f] = fault_active(flt_raw[f], cfg_pol[f]);

        pfg_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk      (clk),
            .rst      (rst),
            .act_raw  (act_raw[f]),
            .act_filt (act_filt[f])
        );

        pfg_status u_stat (
            .clk    (clk),
            .rst    (rst),
            .filt   (act_filt[f]),
            .mode   (flt_mode_e'(cfg_mode[f])),
            .clr    (flt_clr[f]),
            .irq_on (irq_en[f] & ~irq_mask[f]),
            .rd     (sts_rd),
            .st     (flt_status[f]),
            .pend   (irq_pend[f])
        );
    end

    pfg_force #(.NCH(NCH), .NF(NF)) u_force (
        .act_raw (act_raw),
        .status  (flt_status),
        .en      (cfg_en),
        .hval    (cfg_hval),
        .lval    (cfg_lval),
        .h_in    (pwm_h_in),
        .l_in    (pwm_l_in),
        .h_out   (pwm_h_out),
        .l_out   (pwm_l_out),
        .trip    (cnt_rst)
    );

    assign irq = |irq_pend;
endmodule

// File: rtl/pfg_checker.sv
`timescale 1ns/1ps
module pfg_checker #(
    parameter int NCH = 4,
    parameter int NF  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [NF-1:0]     cfg_mode,
    input logic [NCH*NF-1:0] cfg_en,
    input logic [NCH-1:0]    cfg_hval,
    input logic [NCH-1:0]    cfg_lval,
    input logic [NF-1:0]     irq_en,
    input logic [NF-1:0]     irq_mask,
    input logic [NF-1:0]     flt_clr,
    input logic              sts_rd,
    input logic [NCH-1:0]    pwm_h_in,
    input logic [NCH-1:0]    pwm_l_in,
    input logic [NCH-1:0]    pwm_h_out,
    input logic [NCH-1:0]    pwm_l_out,
    input logic [NCH-1:0]    cnt_rst,
    input logic [NF-1:0]     flt_status,
    input logic [NF-1:0]     irq_pend
);
    for (genvar c = 0; c < NCH; c++) begin : g_c
        AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
            !cnt_rst[c] |-> (pwm_h_out[c] == pwm_h_in[c] && pwm_l_out[c] == pwm_l_in[c])); // R1
        AST_SAFE_LEVELS: assert property (@(posedge clk) disable iff (rst)
            cnt_rst[c] |-> (pwm_h_out[c] == cfg_hval[c] && pwm_l_out[c] == cfg_lval[c])); // R2
        for (genvar f = 0; f < NF; f++) begin : g_f
            AST_HELD_FORCES: assert property (@(posedge clk) disable iff (rst)
                (flt_status[f] && cfg_en[c*NF+f]) |-> cnt_rst[c]); // R8
        end
    end

    for (genvar f = 0; f < NF; f++) begin : g_s
        AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
            (cfg_mode[f] && flt_status[f] && !flt_clr[f]) |=> flt_status[f]); // R7
        AST_PEND_GATED: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_pend[f]) |-> ($past(irq_en[f] & ~irq_mask[f]) && $rose(flt_status[f]))); // R9
        AST_PEND_FALL_BY_READ: assert property (@(posedge clk) disable iff (rst)
            $fell(irq_pend[f]) |-> $past(sts_rd)); // R10
        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
            sts_rd |=> (!irq_pend[f] || $rose(flt_status[f]))); // R11
    end
endmodule

bind pwm_fault_guard pfg_checker #(.NCH(NCH), .NF(NF)) u_pfg_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_mode   (cfg_mode),
    .cfg_en     (cfg_en),
    .cfg_hval   (cfg_hval),
    .cfg_lval   (cfg_lval),
    .irq_en     (irq_en),
    .irq_mask   (irq_mask),
    .flt_clr    (flt_clr),
    .sts_rd     (sts_rd),
    .pwm_h_in   (pwm_h_in),
    .pwm_l_in   (pwm_l_in),
    .pwm_h_out  (pwm_h_out),
    .pwm_l_out  (pwm_l_out),
    .cnt_rst    (cnt_rst),
    .flt_status (flt_status),
    .irq_pend   (irq_pend)
);

// File: tb/test_pwm_fault_guard.sv
`timescale 1ns/1ps
module test_pwm_fault_guard;
    localparam int NCH = 4;
    localparam int NF  = 3;
    localparam logic [NCH-1:0] H_IN = 4'b1010;
    localparam logic [NCH-1:0] L_IN = 4'b0101;
    localparam logic [NCH-1:0] HVAL = 4'b0101;
    localparam logic [NCH-1:0] LVAL = 4'b1010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NF-1:0]     flt_raw  = 3'b100;
    logic [NF-1:0]     cfg_pol  = 3'b011;
    logic [NF-1:0]     cfg_mode = 3'b000;
    logic [NCH*NF-1:0] cfg_en   = 12'h151;
    logic [NCH-1:0]    cfg_hval = HVAL;
    logic [NCH-1:0]    cfg_lval = LVAL;
    logic [NF-1:0]     irq_en   = 3'b111;
    logic [NF-1:0]     irq_mask = 3'b000;
    logic [NF-1:0]     flt_clr  = 3'b000;
    logic              sts_rd   = 1'b0;
    logic [NCH-1:0]    pwm_h_in = H_IN;
    logic [NCH-1:0]    pwm_l_in = L_IN;
    logic [NCH-1:0]    pwm_h_out, pwm_l_out, cnt_rst;
    logic [NF-1:0]     flt_status, irq_pend;
    logic              irq;

    pwm_fault_guard #(.NCH(NCH), .NF(NF), .FILT_LEN(3)) i_pwm_fault_guard (
        .clk(clk), .rst(rst), .flt_raw(flt_raw), .cfg_pol(cfg_pol),
        .cfg_mode(cfg_mode), .cfg_en(cfg_en), .cfg_hval(cfg_hval),
        .cfg_lval(cfg_lval), .irq_en(irq_en), .irq_mask(irq_mask),
        .flt_clr(flt_clr), .sts_rd(sts_rd), .pwm_h_in(pwm_h_in),
        .pwm_l_in(pwm_l_in), .pwm_h_out(pwm_h_out), .pwm_l_out(pwm_l_out),
        .cnt_rst(cnt_rst), .flt_status(flt_status), .irq_pend(irq_pend),
        .irq(irq)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          cyc;
        int          sel;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [NCH-1:0] fh(input logic [NCH-1:0] m);
        return (H_IN & ~m) | (HVAL & m);
    endfunction
    function automatic logic [NCH-1:0] fl(input logic [NCH-1:0] m);
        return (L_IN & ~m) | (LVAL & m);
    endfunction

    // sel: 0 h_out, 1 l_out, 2 status, 3 pend, 4 irq, 5 cnt_rst
    task automatic chk(input int d, input int sel, input logic [31:0] v, input string req);
        exp_t e;
        e.cyc = cyc + d; e.sel = sel; e.val = v; e.req = req;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: compares due items away from the active edge.
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc == cyc) begin
                logic [31:0] act;
                case (q[i].sel)
                    0: act = 32'(pwm_h_out);
                    1: act = 32'(pwm_l_out);
                    2: act = 32'(flt_status);
                    3: act = 32'(irq_pend);
                    4: act = 32'(irq);
                    default: act = 32'(cnt_rst);
                endcase
                n_run++;
                if (act !== q[i].val) begin
                    n_fail++;
                    $display("FAIL %s cyc=%0d sel=%0d actual=%0h expected=%0h",
                             q[i].req, cyc, q[i].sel, act, q[i].val);
                end
                q.delete(i);
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        chk(0, 0, H_IN, "R1 reset"); chk(0, 2, 0, "R1 reset");
        chk(0, 3, 0, "R9 reset"); chk(0, 4, 0, "R9 reset"); chk(0, 5, 0, "R4 reset");
        step(1);
        rst = 1'b0;
        step(1);
        // R1: idle pass-through
        chk(0, 0, H_IN, "R1"); chk(0, 1, L_IN, "R1"); chk(0, 5, 0, "R1");
        // R12: hold mode selected while fault 2 inactive
        cfg_mode = 3'b100;
        for (int d = 1; d <= 8; d++) chk(d, 2, 0, "R12");
        step(9);
        cfg_mode = 3'b000;
        step(1);
        // R2/R4/R5/R9: fault 0 asserted (ch0, ch2)
        flt_raw[0] = 1'b1;
        chk(0, 0, fh(4'b0101), "R2"); chk(0, 1, fl(4'b0101), "R2");
        chk(0, 5, 4'b0101, "R4");
        chk(5, 2, 0, "R5"); chk(6, 2, 3'b001, "R5");
        chk(5, 3, 0, "R9"); chk(6, 3, 3'b001, "R9"); chk(6, 4, 1, "R9");
        step(8);
        // R10: read while fault still active
        sts_rd = 1'b1;
        chk(1, 3, 0, "R10"); chk(1, 4, 0, "R10"); chk(1, 2, 3'b001, "R10");
        step(1);
        sts_rd = 1'b0;
        chk(4, 3, 0, "R10");
        step(5);
        // R6: release in follow mode
        flt_raw[0] = 1'b0;
        chk(0, 0, fh(4'b0101), "R6"); chk(5, 2, 3'b001, "R6");
        chk(5, 0, fh(4'b0101), "R6"); chk(6, 2, 0, "R6");
        chk(6, 0, H_IN, "R6"); chk(6, 5, 0, "R6");
        step(8);
        // R5: 2-cycle glitch on fault 1 forces but sets no status
        flt_raw[1] = 1'b1;
        chk(0, 0, fh(4'b0010), "R2");
        step(2);
        flt_raw[1] = 1'b0;
        chk(0, 0, H_IN, "R1");
        for (int d = 0; d <= 8; d++) chk(d, 2, 0, "R5");
        step(10);
        // R3: fault 2 is active-low (ch2)
        flt_raw[2] = 1'b0;
        chk(0, 0, fh(4'b0100), "R3"); chk(0, 1, fl(4'b0100), "R3");
        chk(6, 2, 3'b100, "R3"); chk(6, 3, 3'b100, "R3");
        step(8);
        // R11: read lands on the edge where fault 0 status rises
        flt_raw[0] = 1'b1;
        step(5);
        sts_rd = 1'b1;
        chk(1, 3, 3'b001, "R11"); chk(1, 4, 1, "R11");
        step(1);
        sts_rd = 1'b0;
        step(2);
        sts_rd = 1'b1;
        chk(1, 3, 0, "R10");
        step(1);
        sts_rd = 1'b0;
        flt_raw[0] = 1'b0;
        flt_raw[2] = 1'b1;
        step(10);
        chk(0, 0, H_IN, "R6"); chk(0, 2, 0, "R6"); chk(0, 3, 0, "R10");
        // R7/R8/R9: hold mode with masked interrupt on fault 1 (ch1)
        cfg_mode[1] = 1'b1;
        irq_mask[1] = 1'b1;
        step(1);
        flt_raw[1] = 1'b1;
        chk(6, 2, 3'b010, "R7"); chk(6, 3, 0, "R9"); chk(6, 4, 0, "R9");
        step(8);
        flt_clr[1] = 1'b1;
        chk(1, 2, 3'b010, "R7");
        step(1);
        flt_clr[1] = 1'b0;
        step(4);
        flt_raw[1] = 1'b0;
        chk(0, 0, fh(4'b0010), "R8");
        chk(10, 2, 3'b010, "R7"); chk(10, 0, fh(4'b0010), "R8");
        chk(10, 5, 4'b0010, "R8");
        step(12);
        flt_clr[1] = 1'b1;
        chk(1, 2, 0, "R7"); chk(1, 0, H_IN, "R8"); chk(1, 5, 0, "R8");
        step(1);
        flt_clr[1] = 1'b0;
        step(3);
        chk(0, 3, 0, "R9");
        step(2);
        while (q.size() != 0) step(1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule